// File: doc/BRIEF.md
# Host-Window AXI4-Lite Command Bridge

This block lets a controller that only has a narrow 16-bit register port run single 32-bit AXI4-Lite reads and writes. The host fills in a target address and, for writes, a data word, each as two 16-bit halves. It then writes a command code into the control register. The bridge drives exactly one AXI4-Lite beat on the master side and records the outcome as a sticky event in the status register. The host learns of the outcome by polling status, or through an interrupt line gated by per-event enables.

Each transfer ends with exactly one outcome: success, a slave error, or a timeout when the slave stays silent for a set number of cycles. Two command variants advance the held address by one word after a successful transfer, so a host can walk a block of registers without reloading the address. A level interrupt from the AXI side is shown in status and can also raise the interrupt output. Commands that arrive while a transfer is in flight are dropped, and so are writes to the address and data halves.

Top module: `axil_cmd_bridge`

## Requirements
- R1: Host byte offsets: 0x0 status, 0x2 control, 0x4/0x6 address low/high half, 0x8/0xA write-data low/high half, 0xC/0xE read-data low/high half. The address and write-data halves read back what was written. An odd offset reads as zero and is not written.
- R2: Control command 0xA (or 0xB) starts one AXI read at the 32-bit held address. A successful result appears at 0xC/0xE. It sets status bit 15 (read complete) and bit 7 (read data available). Busy (status bit 6) is high for 3 + L host cycles, where L is the slave's response delay after the address handshake.
- R3: Command 0x8 (or 0x9) starts one AXI write of the held data to the held address with all four byte strobes set. It sets status bit 14 (write complete). Busy is high for 3 + L cycles.
- R4: Commands 0x9 and 0xB add 4 to the held address after a successful transfer. After an error or timeout the address is left unchanged.
- R5: A response code of 2 or 3 sets status bit 12 (error) instead of the complete event. A rejected write leaves the target's memory unchanged.
- R6: If the slave has not completed within TIMEOUT_CYC cycles of the launch, the transfer is dropped. Busy falls after exactly TIMEOUT_CYC cycles, and status bit 13 (timeout) is set.
- R7: Status bits 15:12 are sticky. Writing 1 to a bit at offset 0x0 clears it; writing 0 leaves it unchanged.
- R8: Status bit 11 follows the downstream interrupt input. The interrupt output is the OR of every status bit 15:11 whose enable, control bit 15:11, is set.
- R9: While busy, new commands and writes to the address and write-data halves have no effect.
- R10: Each launched transfer produces exactly one AXI handshake and exactly one of the events in bits 15:12. Command 0x0 and other unused codes start nothing.
- R11: After reset, status reads 0x0020 (initialisation done, bit 5), all other registers read zero and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host byte offset into the window |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr, combinational |
| axi_irq_i | input | 1 | Interrupt level from the AXI side |
| irq_o | output | 1 | Combined enabled-event interrupt |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | 32 | Write address |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Byte strobes, always all set |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | 32 | Read address |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response code |

## Verification
Busy rises at the clock edge that takes the command. Status, read data and interrupt change at the same edge that takes the response. Register reads are combinational, so a transfer against a slave that answers L cycles after the address handshake shows busy for exactly 3 + L host cycles. A silent slave shows busy for exactly TIMEOUT_CYC cycles. The bench samples status one time unit after each falling edge, counts the cycles for which busy is seen high, and compares the count with these figures. It reads the events, the data halves and the address only after busy has fallen, when the outcome is already registered.

// File: rtl/axb_pkg.sv
package axb_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int STRB_W = WORD_W / 8;

    // command codes in control bits 3:0
    localparam logic [3:0] CMD_NOP    = 4'h0;
    localparam logic [3:0] CMD_WR     = 4'h8;
    localparam logic [3:0] CMD_WR_INC = 4'h9;
    localparam logic [3:0] CMD_RD     = 4'hA;
    localparam logic [3:0] CMD_RD_INC = 4'hB;

    // host word index = byte offset / 2
    localparam logic [2:0] IDX_STAT  = 3'd0;
    localparam logic [2:0] IDX_CTRL  = 3'd1;
    localparam logic [2:0] IDX_AD_LO = 3'd2;
    localparam logic [2:0] IDX_AD_HI = 3'd3;
    localparam logic [2:0] IDX_WD_LO = 3'd4;
    localparam logic [2:0] IDX_WD_HI = 3'd5;
    localparam logic [2:0] IDX_RD_LO = 3'd6;
    localparam logic [2:0] IDX_RD_HI = 3'd7;

    typedef enum logic [1:0] {RES_OK, RES_ERR, RES_TMO} res_e;
    typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_READ} st_e;
endpackage

// File: rtl/axb_master.sv
module axb_master
    import axb_pkg::*;
#(
    parameter int TIMEOUT_CYC = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_read_i,
    input  logic [WORD_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output res_e              result_o,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [WORD_W-1:0] m_awaddr,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [WORD_W-1:0] m_wdata,
    output logic [STRB_W-1:0] m_wstrb,
    input  logic              m_bvalid,
    output logic              m_bready,
    input  logic [1:0]        m_bresp,
    output logic              m_arvalid,
    input  logic              m_arready,
    output logic [WORD_W-1:0] m_araddr,
    input  logic              m_rvalid,
    output logic              m_rready,
    input  logic [1:0]        m_rresp
);
    localparam int CNT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        st_e              st;
        logic             aw_pend;
        logic             w_pend;
        logic             ar_pend;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic [CNT_W-1:0] cnt;
    } m_s;

    m_s   q, d;
    logic resp_now;
    logic resp_bad;
    logic tmo_now;

    always_comb begin
        d        = q;
        done_o   = 1'b0;
        result_o = RES_OK;
        resp_now = 1'b0;
        resp_bad = 1'b0;
        tmo_now  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st      = is_read_i ? ST_READ : ST_WRITE;
                    d.addr    = addr_i;
                    d.wdata   = wdata_i;
                    d.cnt     = '0;
                    d.aw_pend = !is_read_i;
                    d.w_pend  = !is_read_i;
                    d.ar_pend = is_read_i;
                end
            end
            ST_WRITE, ST_READ: begin
                if (m_awvalid && m_awready) d.aw_pend = 1'b0;
                if (m_wvalid && m_wready)   d.w_pend  = 1'b0;
                if (m_arvalid && m_arready) d.ar_pend = 1'b0;
                if (q.st == ST_WRITE) begin
                    resp_now = m_bvalid;
                    resp_bad = (m_bresp == 2'b10) || (m_bresp == 2'b11);
                end else begin
                    resp_now = m_rvalid;
                    resp_bad = (m_rresp == 2'b10) || (m_rresp == 2'b11);
                end
                tmo_now = !resp_now && (q.cnt == CNT_LAST);
                if (resp_now || tmo_now) begin
                    done_o    = 1'b1;
                    result_o  = tmo_now ? RES_TMO : (resp_bad ? RES_ERR : RES_OK);
                    d.st      = ST_IDLE;
                    d.aw_pend = 1'b0;
                    d.w_pend  = 1'b0;
                    d.ar_pend = 1'b0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, aw_pend: 1'b0, w_pend: 1'b0, ar_pend: 1'b0,
                   addr: '0, wdata: '0, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o    = (q.st != ST_IDLE);
    assign m_awvalid = q.aw_pend;
    assign m_wvalid  = q.w_pend;
    assign m_arvalid = q.ar_pend;
    assign m_awaddr  = q.addr;
    assign m_araddr  = q.addr;
    assign m_wdata   = q.wdata;
    assign m_wstrb   = '1;
    assign m_bready  = (q.st == ST_WRITE);
    assign m_rready  = (q.st == ST_READ);

    // R2: a pending read address is held steady until taken or abandoned
    p_arvalid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready && !tmo_now) |=> (m_arvalid && $stable(m_araddr)));

    // R6: the wait counter never runs past the timeout window
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (q.cnt <= CNT_LAST));

    // R10: an outcome always ends the transfer
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
endmodule

// File: rtl/axb_regs.sv
module axb_regs
    import axb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [3:0]        host_addr,
    input  logic [HALF_W-1:0] host_wdata,
    output logic [HALF_W-1:0] host_rdata,
    input  logic              axi_irq_i,
    output logic              irq_o,
    input  logic              busy_i,
    input  logic              done_i,
    input  res_e              result_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic              start_o,
    output logic              is_read_o,
    output logic [WORD_W-1:0] addr_o,
    output logic [WORD_W-1:0] wdata_o
);
    // ev: 3 read done, 2 write done, 1 timeout, 0 error
    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] rdata;
        logic [3:0]        ev;
        logic [4:0]        en;
        logic              rd_avail;
        logic              init_done;
        logic              op_rd;
        logic              op_inc;
    } r_s;

    r_s                q, d;
    logic              wr;
    logic [2:0]        idx;
    logic [3:0]        cmd;
    logic              cmd_ok;
    logic [3:0]        clr_mask;
    logic [HALF_W-1:0] status;
    logic [3:0]        ev_q;

    assign idx    = host_addr[3:1];
    assign wr     = host_we && !host_addr[0];
    assign cmd    = host_wdata[3:0];
    assign cmd_ok = (cmd == CMD_WR) || (cmd == CMD_WR_INC) ||
                    (cmd == CMD_RD) || (cmd == CMD_RD_INC);

    always_comb begin
        d           = q;
        d.init_done = 1'b1;
        clr_mask    = '0;
        start_o     = wr && (idx == IDX_CTRL) && cmd_ok && !busy_i;
        if (wr) begin
            unique case (idx)
                IDX_STAT:  clr_mask = host_wdata[15:12];
                IDX_CTRL:  d.en = host_wdata[15:11];
                IDX_AD_LO: if (!busy_i) d.addr[HALF_W-1:0]       = host_wdata;
                IDX_AD_HI: if (!busy_i) d.addr[WORD_W-1:HALF_W]  = host_wdata;
                IDX_WD_LO: if (!busy_i) d.wdata[HALF_W-1:0]      = host_wdata;
                IDX_WD_HI: if (!busy_i) d.wdata[WORD_W-1:HALF_W] = host_wdata;
                default: ;
            endcase
        end
        d.ev = q.ev & ~clr_mask;
        if (start_o) begin
            d.op_rd    = cmd[1];
            d.op_inc   = cmd[0];
            d.rd_avail = 1'b0;
        end
        if (done_i) begin
            unique case (result_i)
                RES_OK: begin
                    if (q.op_rd) begin
                        d.ev[3]    = 1'b1;
                        d.rdata    = rdata_i;
                        d.rd_avail = 1'b1;
                    end else begin
                        d.ev[2] = 1'b1;
                    end
                    if (q.op_inc) d.addr = q.addr + WORD_W'(4);
                end
                RES_ERR: d.ev[0] = 1'b1;
                default: d.ev[1] = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ev_q   = q.ev;
    assign status = {q.ev, axi_irq_i, 3'b000, q.rd_avail, busy_i, q.init_done, 5'b00000};

    always_comb begin
        host_rdata = '0;
        if (!host_addr[0]) begin
            unique case (idx)
                IDX_STAT:  host_rdata = status;
                IDX_CTRL:  host_rdata = {q.en, 11'b0};
                IDX_AD_LO: host_rdata = q.addr[HALF_W-1:0];
                IDX_AD_HI: host_rdata = q.addr[WORD_W-1:HALF_W];
                IDX_WD_LO: host_rdata = q.wdata[HALF_W-1:0];
                IDX_WD_HI: host_rdata = q.wdata[WORD_W-1:HALF_W];
                IDX_RD_LO: host_rdata = q.rdata[HALF_W-1:0];
                default:   host_rdata = q.rdata[WORD_W-1:HALF_W];
            endcase
        end
    end

    assign irq_o     = |(status[15:11] & q.en);
    assign is_read_o = cmd[1];
    assign addr_o    = q.addr;
    assign wdata_o   = q.wdata;

    // R7: an event survives unless its own clear bit was written
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ev_q & $past(ev_q & ~clr_mask)) == $past(ev_q & ~clr_mask)));

    // R9: no launch while a transfer is in flight
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !busy_i);

    // R9: address is frozen while busy and not finishing
    p_addr_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !done_i) |=> $stable(addr_o));

    // R2: a good read leaves data available
    p_rdavail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && (result_i == RES_OK) && q.op_rd) |=> (status[7] && status[15]));

    // R8: enabled external interrupt reaches the output
    p_irq_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (axi_irq_i && q.en[0]) |-> irq_o);
endmodule

// File: rtl/axil_cmd_bridge.sv
module axil_cmd_bridge
    import axb_pkg::*;
#(
    parameter int TIMEOUT_CYC = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [3:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic        axi_irq_i,
    output logic        irq_o,
    output logic        m_awvalid,
    input  logic        m_awready,
    output logic [31:0] m_awaddr,
    output logic        m_wvalid,
    input  logic        m_wready,
    output logic [31:0] m_wdata,
    output logic [3:0]  m_wstrb,
    input  logic        m_bvalid,
    output logic        m_bready,
    input  logic [1:0]  m_bresp,
    output logic        m_arvalid,
    input  logic        m_arready,
    output logic [31:0] m_araddr,
    input  logic        m_rvalid,
    output logic        m_rready,
    input  logic [31:0] m_rdata,
    input  logic [1:0]  m_rresp
);
    logic              busy;
    logic              done;
    res_e              result;
    logic              start;
    logic              is_read;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] wdata;

    axb_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .axi_irq_i  (axi_irq_i),
        .irq_o      (irq_o),
        .busy_i     (busy),
        .done_i     (done),
        .result_i   (result),
        .rdata_i    (m_rdata),
        .start_o    (start),
        .is_read_o  (is_read),
        .addr_o     (addr),
        .wdata_o    (wdata)
    );

    axb_master #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .is_read_i (is_read),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .busy_o    (busy),
        .done_o    (done),
        .result_o  (result),
        .m_awvalid (m_awvalid),
        .m_awready (m_awready),
        .m_awaddr  (m_awaddr),
        .m_wvalid  (m_wvalid),
        .m_wready  (m_wready),
        .m_wdata   (m_wdata),
        .m_wstrb   (m_wstrb),
        .m_bvalid  (m_bvalid),
        .m_bready  (m_bready),
        .m_bresp   (m_bresp),
        .m_arvalid (m_arvalid),
        .m_arready (m_arready),
        .m_araddr  (m_araddr),
        .m_rvalid  (m_rvalid),
        .m_rready  (m_rready),
        .m_rresp   (m_rresp)
    );
endmodule

// File: tb/axil_cmd_bridge_test.sv
`timescale 1ns/1ps
module axil_cmd_bridge_test;
    localparam int TMO = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = 4'h0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        axi_irq_i = 1'b0;
    logic        irq_o;
    logic        m_awvalid, m_awready, m_wvalid, m_wready;
    logic        m_bvalid, m_bready, m_arvalid, m_arready;
    logic        m_rvalid, m_rready;
    logic [31:0] m_awaddr, m_wdata, m_araddr, m_rdata;
    logic [3:0]  m_wstrb;
    logic [1:0]  m_bresp, m_rresp;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    axil_cmd_bridge #(.TIMEOUT_CYC(TMO)) uut (.*);

    // ---------------- slave model ----------------
    logic        mute = 1'b0;
    logic [3:0]  lat = 4'd0;
    logic [1:0]  resp = 2'b00;
    logic [31:0] mem [16];
    logic        rd_pend, wr_pend;
    logic [3:0]  cnt;
    logic [31:0] last_ar, last_aw, last_wd;
    logic [3:0]  last_strb;
    int          txn_cnt = 0;
    int          aw_cycles = 0;

    assign m_awready = !mute;
    assign m_wready  = !mute;
    assign m_arready = !mute;

    always @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0; wr_pend <= 1'b0; cnt <= '0;
            m_rvalid <= 1'b0; m_bvalid <= 1'b0;
            m_rdata <= '0; m_rresp <= '0; m_bresp <= '0;
            last_ar <= '0; last_aw <= '0; last_wd <= '0; last_strb <= '0;
        end else begin
            if (m_awvalid) aw_cycles <= aw_cycles + 1;
            if (m_arvalid && m_arready) begin
                rd_pend <= 1'b1; cnt <= lat; last_ar <= m_araddr;
                txn_cnt <= txn_cnt + 1;
            end
            if (m_awvalid && m_awready) begin
                wr_pend <= 1'b1; cnt <= lat; last_aw <= m_awaddr;
                txn_cnt <= txn_cnt + 1;
            end
            if (m_wvalid && m_wready) begin
                last_wd <= m_wdata; last_strb <= m_wstrb;
            end
            if (rd_pend) begin
                if (cnt != 0) cnt <= cnt - 1'b1;
                else begin
                    m_rvalid <= 1'b1; m_rdata <= mem[last_ar[5:2]];
                    m_rresp <= resp; rd_pend <= 1'b0;
                end
            end
            if (wr_pend) begin
                if (cnt != 0) cnt <= cnt - 1'b1;
                else begin
                    m_bvalid <= 1'b1; m_bresp <= resp; wr_pend <= 1'b0;
                    if (resp[1] == 1'b0) mem[last_aw[5:2]] <= last_wd;
                end
            end
            if (m_rvalid && m_rready) m_rvalid <= 1'b0;
            if (m_bvalid && m_bready) m_bvalid <= 1'b0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic hwr(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = v;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hrd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic hrd32(input logic [3:0] a, output logic [31:0] v);
        logic [15:0] lo, hi;
        hrd(a, lo);
        hrd(a + 4'd2, hi);
        v = {hi, lo};
    endtask

    // counts cycles with busy high, starting at the falling edge after launch
    task automatic wait_idle(output int n);
        n = 0;
        host_addr = 4'h0;
        #1;
        while (host_rdata[6] && n < 1000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic setup(input logic [31:0] a, input logic [31:0] v);
        hwr(4'h4, a[15:0]);  hwr(4'h6, a[31:16]);
        hwr(4'h8, v[15:0]);  hwr(4'hA, v[31:16]);
    endtask

    // {cmd, lat, resp, addr, data}
    localparam logic [73:0] VEC [8] = '{
        {4'h8, 4'd0, 2'd0, 32'h0000_0010, 32'hDEAD_BEEF},
        {4'hA, 4'd2, 2'd0, 32'h0000_0010, 32'h0},
        {4'h9, 4'd1, 2'd0, 32'h0000_0020, 32'h1234_5678},
        {4'hB, 4'd0, 2'd0, 32'h0000_0020, 32'h0},
        {4'h8, 4'd0, 2'd2, 32'h0000_0030, 32'hAAAA_5555},
        {4'hB, 4'd3, 2'd3, 32'h0000_0030, 32'h0},
        {4'hA, 4'd0, 2'd0, 32'h0000_0030, 32'h0},
        {4'h9, 4'd5, 2'd0, 32'h0000_003C, 32'h0BAD_F00D}
    };

    logic [31:0] exp_mem [16];

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] h;
        logic [31:0] w;
        int n, t0;
        for (int i = 0; i < 16; i++) begin
            mem[i] = 32'hA500_0000 | i;
            exp_mem[i] = 32'hA500_0000 | i;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);

        // R11 reset state
        hrd(4'h0, h); chk("R11 status after reset", {16'h0, h}, 32'h0020);
        hrd(4'h2, h); chk("R11 control after reset", {16'h0, h}, 32'h0);
        hrd32(4'h4, w); chk("R11 address after reset", w, 32'h0);
        hrd32(4'hC, w); chk("R11 read data after reset", w, 32'h0);
        chk("R11 irq after reset", {31'h0, irq_o}, 32'h0);

        // R1 window readback and odd offset
        setup(32'hCAFE_0008, 32'h5A5A_A5A5);
        hrd32(4'h4, w); chk("R1 address halves", w, 32'hCAFE_0008);
        hrd32(4'h8, w); chk("R1 write data halves", w, 32'h5A5A_A5A5);
        hwr(4'h5, 16'hFFFF);
        hrd(4'h5, h); chk("R1 odd offset reads zero", {16'h0, h}, 32'h0);
        hrd32(4'h4, w); chk("R1 odd offset writes nothing", w, 32'hCAFE_0008);

        // vector table
        foreach (VEC[k]) begin
            logic [3:0]  cmd = VEC[k][73:70];
            logic [3:0]  vl  = VEC[k][69:66];
            logic [1:0]  vr  = VEC[k][65:64];
            logic [31:0] va  = VEC[k][63:32];
            logic [31:0] vd  = VEC[k][31:0];
            logic ok = (vr[1] == 1'b0);
            logic rd = cmd[1];
            logic [31:0] exp_ev;
            hwr(4'h0, 16'hF000);
            lat = vl; resp = vr;
            setup(va, vd);
            t0 = txn_cnt;
            hwr(4'h2, {12'h0, cmd});
            wait_idle(n);
            chk(rd ? "R2 busy cycles" : "R3 busy cycles", n, 3 + vl);
            exp_ev = !ok ? 32'h1 : (rd ? 32'h8 : 32'h4);
            hrd(4'h0, h);
            chk(ok ? "R10 single event" : "R5 error event", {28'h0, h[15:12]}, exp_ev);
            chk("R10 one handshake", txn_cnt - t0, 1);
            if (rd) begin
                chk("R2 read address", last_ar, va);
                chk("R2 data available", {31'h0, h[7]}, {31'h0, ok});
                if (ok) begin
                    hrd32(4'hC, w); chk("R2 read data", w, exp_mem[va[5:2]]);
                end
            end else begin
                chk("R3 write address", last_aw, va);
                chk("R3 write data", last_wd, vd);
                chk("R3 strobes", {28'h0, last_strb}, 32'hF);
                chk("R2 data available cleared by launch", {31'h0, h[7]}, 32'h0);
                if (ok) exp_mem[va[5:2]] = vd;
            end
            chk("R5 target memory", mem[va[5:2]], exp_mem[va[5:2]]);
            hrd32(4'h4, w);
            chk("R4 address after transfer", w, (cmd[0] && ok) ? va + 32'd4 : va);
        end

        // R6 timeout with exact busy length
        hwr(4'h0, 16'hF000);
        mute = 1'b1;
        setup(32'h0000_0050, 32'h1111_2222);
        hwr(4'h2, {12'h0, 4'hB});
        wait_idle(n);
        chk("R6 timeout busy cycles", n, TMO);
        hrd(4'h0, h); chk("R6 timeout event only", {28'h0, h[15:12]}, 32'h2);
        hrd32(4'h4, w); chk("R4 no increment on timeout", w, 32'h0000_0050);

        // R9 writes while busy are ignored
        hwr(4'h0, 16'hF000);
        aw_cycles = 0;
        hwr(4'h2, {12'h0, 4'hA});
        hwr(4'h4, 16'hFFFF);
        hwr(4'h8, 16'hFFFF);
        hwr(4'h2, {12'h0, 4'h8});
        wait_idle(n);
        hrd32(4'h4, w); chk("R9 address kept while busy", w, 32'h0000_0050);
        hrd32(4'h8, w); chk("R9 write data kept while busy", w, 32'h1111_2222);
        hrd(4'h0, h); chk("R9 no second command", {28'h0, h[15:12]}, 32'h2);
        chk("R9 no write issued", aw_cycles, 0);
        mute = 1'b0;

        // R8 interrupt and R7 clear semantics
        hwr(4'h0, 16'hF000);
        lat = 0; resp = 0;
        hwr(4'h2, 16'h4000 | 16'h8);
        wait_idle(n);
        chk("R8 irq on enabled write done", {31'h0, irq_o}, 32'h1);
        t0 = txn_cnt;
        hwr(4'h2, 16'h0000);
        chk("R8 irq off when disabled", {31'h0, irq_o}, 32'h0);
        hrd(4'h0, h);
        chk("R10 nop starts nothing", {31'h0, h[6]}, 32'h0);
        chk("R10 nop no handshake", txn_cnt - t0, 0);
        hwr(4'h2, 16'h0007);
        hrd(4'h0, h);
        chk("R10 unused code starts nothing", {31'h0, h[6]}, 32'h0);
        hwr(4'h0, 16'h0000);
        hrd(4'h0, h); chk("R7 zero write keeps event", {28'h0, h[15:12]}, 32'h4);
        hwr(4'h0, 16'h8000);
        hrd(4'h0, h); chk("R7 other bit clear keeps event", {28'h0, h[15:12]}, 32'h4);
        hwr(4'h0, 16'h4000);
        hrd(4'h0, h); chk("R7 one write clears event", {28'h0, h[15:12]}, 32'h0);
        axi_irq_i = 1'b1;
        hrd(4'h0, h); chk("R8 status shows ext irq", {31'h0, h[11]}, 32'h1);
        chk("R8 ext irq masked", {31'h0, irq_o}, 32'h0);
        hwr(4'h2, 16'h0800);
        chk("R8 ext irq enabled", {31'h0, irq_o}, 32'h1);
        axi_irq_i = 1'b0;
        #1 chk("R8 ext irq follows input", {31'h0, irq_o}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule